// File: doc/BRIEF.md
# Converter Setup and Calibration Sequencer

This block sits in the digital control section of a sigma-delta converter. It holds the eight-bit configuration register and drives the converter's gain, coding and input-buffer controls from it. It also sequences the work that the register selects: filter settling after synchronisation, the three calibration flavours, and the data-ready handshake with the host.

A simple parallel port writes the register and reads it back. The converter back end pulses `upd_strobe` at the end of every output update period, and every timed interval in the block is counted in those strobes. A host read of the conversion result is signalled on `data_rd` and marks the result as consumed. Calibration clears its own mode field once it finishes. Setting the synchronisation bit holds the filter and the sequencer in reset, but leaves an already-low data-ready flag alone.

Top module: `adc_setup_seq`

## Requirements
- R1: After reset the register reads 0x01, `drdy_n` is 1, `filt_rst` is 1, and both calibration indicators are 0.
- R2: Field layout, from bit 7 to bit 0: mode[1:0], gain code[2:0], coding, buffer, sync. The value read back equals the last value written, except where R4 clears the mode field. `gain_code` is bits 5:3, and `gain_factor` is 2 to the power of that code (1 for 000, 128 for 111). `unipolar` is bit 2 (0 means bipolar). `buf_en` is bit 1. `filt_rst` is bit 0.
- R3: A write with sync 0 and mode 01 (self calibration) runs a zero-scale step (`cal_zero`=1) and then a full-scale step (`cal_full`=1). Mode 10 runs only the zero-scale step. Mode 11 runs only the full-scale step. Mode 00 is normal conversion.
- R4: Each calibration step lasts 3 update strobes, and each step starts from the cycle after the write. On the strobe that completes the last step, the mode field becomes 00, and the next read returns the register with bits 7:6 cleared.
- R5: `drdy_n` is 1 from the cycle after a calibration-starting write through the whole calibration. It goes to 0 in the cycle after the completing strobe.
- R6: While sync is 1, no calibration runs, both indicators are 0, and strobes change nothing. A calibration mode written together with sync=1 stays pending in the register with its mode bits intact.
- R7: After a write of normal mode with sync 0 that releases sync, `drdy_n` stays as it was for 2 strobes. It goes to 0 after the third strobe.
- R8: In normal running, each strobe drives `drdy_n` to 0 on the next cycle, and a `data_rd` pulse drives it to 1. When a strobe and a read arrive in the same cycle, the strobe wins.
- R9: Writing sync=1 while `drdy_n` is 0 keeps it at 0. `data_rd` still sets it to 1 while sync is held.
- R10: Any write during a calibration aborts the calibration and keeps `drdy_n` at 1. A new calibration mode restarts the step count from zero. Sync=1 returns the block to hold and keeps the mode bits pending. Mode 00 with sync 0 goes to settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read-back value |
| upd_strobe | input | 1 | One-cycle pulse at the end of each output update period |
| data_rd | input | 1 | Host has read the conversion result |
| gain_code | output | 3 | Selected gain code |
| gain_factor | output | 8 | Decoded gain, 2^gain_code |
| unipolar | output | 1 | 1 = unipolar coding, 0 = bipolar |
| buf_en | output | 1 | Input buffer in series |
| filt_rst | output | 1 | Filter and modulator held in reset |
| cal_zero | output | 1 | Zero-scale calibration step active |
| cal_full | output | 1 | Full-scale calibration step active |
| drdy_n | output | 1 | Data-ready, active low |

## Verification
Each calibration mode is driven from a fresh write. Self calibration is the only mode that shows the zero-to-full hand-over, so running all three apart separates the modes and confirms that mode clearing follows the last step only. Strobe counts are stepped one at a time, which tells a 3-period step apart from an off-by-one. Writes that land in the middle of a step separate a true restart from a resumed count. A sync write is made while data-ready is low, and another while a calibration mode is pending, which separates "hold without disturbing" from a plain reset of the flag.

// File: rtl/adc_setup_pkg.sv
package adc_setup_pkg;

    localparam int REG_W     = 8;
    localparam int GAIN_BITS = 3;

    localparam int MODE_HI  = 7;
    localparam int MODE_LO  = 6;
    localparam int GAIN_HI  = 5;
    localparam int GAIN_LO  = 3;
    localparam int CODE_BIT = 2;
    localparam int BUF_BIT  = 1;
    localparam int SYNC_BIT = 0;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_SELF   = 2'b01,
        MODE_ZSYS   = 2'b10,
        MODE_FSYS   = 2'b11
    } cal_mode_e;

    typedef enum logic [2:0] {
        SQ_HOLD,
        SQ_SETTLE,
        SQ_RUN,
        SQ_ZERO,
        SQ_FULL
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       drdy_n;
        logic       two_step;
    } seq_regs_t;

endpackage

// File: rtl/adc_setup_reg.sv
module adc_setup_reg
    import adc_setup_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             cal_done_i,
    output logic [REG_W-1:0] reg_o
);

    localparam logic [REG_W-1:0] RESET_VAL = REG_W'(1) << SYNC_BIT;

    logic [REG_W-1:0] reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_en_i) begin
            reg_d = wr_data_i;
        end else if (cal_done_i) begin
            reg_d[MODE_HI:MODE_LO] = MODE_NORMAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= RESET_VAL;
        else        reg_q <= reg_d;
    end

    assign reg_o = reg_q;

    // R4: finishing a calibration leaves the mode field at normal
    assert_mode_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done_i && !wr_en_i) |=> (reg_q[MODE_HI:MODE_LO] == MODE_NORMAL));

    // R2: a write is reflected exactly on the next cycle
    assert_write_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (reg_q == $past(wr_data_i)));

endmodule

// File: rtl/adc_period_cnt.sv
module adc_period_cnt #(
    parameter int MAX_PERIODS = 3,
    localparam int CW = $clog2(MAX_PERIODS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          strobe_i,
    input  logic [CW-1:0] target_i,
    output logic          done_o
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          last;

    assign last   = (cnt_q == CW'(target_i - 1'b1));
    assign done_o = strobe_i && last;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (strobe_i) begin
            cnt_d = last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4/R7: the period count never reaches the longest interval
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < CW'(MAX_PERIODS)));

endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
    import adc_setup_pkg::*;
#(
    parameter int STEP_PERIODS   = 3,
    parameter int SETTLE_PERIODS = 3,
    localparam int MAXP = (STEP_PERIODS > SETTLE_PERIODS) ? STEP_PERIODS : SETTLE_PERIODS,
    localparam int CW   = $clog2(MAXP + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [1:0] wr_mode_i,
    input  logic       wr_sync_i,
    input  logic       sync_i,
    input  logic       strobe_i,
    input  logic       data_rd_i,
    output logic       cal_done_o,
    output logic       cal_zero_o,
    output logic       cal_full_o,
    output logic       drdy_n_o
);

    seq_regs_t     cur_q, nxt_d;
    logic          cnt_clear;
    logic          cnt_done;
    logic [CW-1:0] cnt_target;
    logic          finish;

    assign cnt_target = (cur_q.state == SQ_SETTLE) ? CW'(SETTLE_PERIODS) : CW'(STEP_PERIODS);

    adc_period_cnt #(.MAX_PERIODS(MAXP)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (cnt_clear),
        .strobe_i (strobe_i),
        .target_i (cnt_target),
        .done_o   (cnt_done)
    );

    always_comb begin
        nxt_d  = cur_q;
        finish = 1'b0;

        if (data_rd_i) nxt_d.drdy_n = 1'b1;

        if (wr_en_i) begin
            if (wr_sync_i) begin
                nxt_d.state = SQ_HOLD;
            end else if (cal_mode_e'(wr_mode_i) != MODE_NORMAL) begin
                nxt_d.drdy_n   = 1'b1;
                nxt_d.two_step = (cal_mode_e'(wr_mode_i) == MODE_SELF);
                nxt_d.state    = (cal_mode_e'(wr_mode_i) == MODE_FSYS) ? SQ_FULL : SQ_ZERO;
            end else if (cur_q.state == SQ_HOLD || cur_q.state == SQ_ZERO ||
                         cur_q.state == SQ_FULL) begin
                nxt_d.state = SQ_SETTLE;
            end
        end else begin
            unique case (cur_q.state)
                SQ_HOLD: ;
                SQ_SETTLE: begin
                    if (cnt_done) begin
                        nxt_d.state  = SQ_RUN;
                        nxt_d.drdy_n = 1'b0;
                    end
                end
                SQ_RUN: begin
                    if (strobe_i) nxt_d.drdy_n = 1'b0;
                end
                SQ_ZERO: begin
                    if (cnt_done) begin
                        if (cur_q.two_step) nxt_d.state = SQ_FULL;
                        else                finish      = 1'b1;
                    end
                end
                SQ_FULL: begin
                    if (cnt_done) finish = 1'b1;
                end
                default: nxt_d.state = SQ_HOLD;
            endcase
            if (finish) begin
                nxt_d.state    = SQ_RUN;
                nxt_d.drdy_n   = 1'b0;
                nxt_d.two_step = 1'b0;
            end
        end
    end

    assign cnt_clear  = wr_en_i || (nxt_d.state != cur_q.state);
    assign cal_done_o = finish;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state    <= SQ_HOLD;
            cur_q.drdy_n   <= 1'b1;
            cur_q.two_step <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cal_zero_o = (cur_q.state == SQ_ZERO);
    assign cal_full_o = (cur_q.state == SQ_FULL);
    assign drdy_n_o   = cur_q.drdy_n;

    // R5: data-ready is never low while a calibration step is active
    assert_drdy_cal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_zero_o || cal_full_o) |-> drdy_n_o);

    // R6: sync set in the register means the sequencer is holding
    assert_sync_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |-> (cur_q.state == SQ_HOLD));

    // R8: a strobe in normal running makes a result available
    assert_strobe_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == SQ_RUN && strobe_i && !wr_en_i) |=> !drdy_n_o);

    // R9: holding does not disturb a low data-ready
    assert_hold_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == SQ_HOLD && !drdy_n_o && !data_rd_i && !wr_en_i) |=> !drdy_n_o);

    // R10: a calibration write starts a step with data-ready high
    assert_cal_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sync_i && wr_mode_i != 2'b00) |=> (drdy_n_o && (cal_zero_o || cal_full_o)));

    // R3: at most one step indicator at a time
    assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cal_zero_o, cal_full_o}));

endmodule

// File: rtl/adc_setup_seq.sv
module adc_setup_seq
    import adc_setup_pkg::*;
#(
    parameter int STEP_PERIODS   = 3,
    parameter int SETTLE_PERIODS = 3,
    localparam int FACT_W = 1 << GAIN_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic                 upd_strobe,
    input  logic                 data_rd,
    output logic [GAIN_BITS-1:0] gain_code,
    output logic [FACT_W-1:0]    gain_factor,
    output logic                 unipolar,
    output logic                 buf_en,
    output logic                 filt_rst,
    output logic                 cal_zero,
    output logic                 cal_full,
    output logic                 drdy_n
);

    logic [REG_W-1:0] cfg;
    logic             cal_done;

    adc_setup_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .cal_done_i (cal_done),
        .reg_o      (cfg)
    );

    adc_cal_seq #(
        .STEP_PERIODS   (STEP_PERIODS),
        .SETTLE_PERIODS (SETTLE_PERIODS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_mode_i  (wr_data[MODE_HI:MODE_LO]),
        .wr_sync_i  (wr_data[SYNC_BIT]),
        .sync_i     (cfg[SYNC_BIT]),
        .strobe_i   (upd_strobe),
        .data_rd_i  (data_rd),
        .cal_done_o (cal_done),
        .cal_zero_o (cal_zero),
        .cal_full_o (cal_full),
        .drdy_n_o   (drdy_n)
    );

    assign rd_data   = cfg;
    assign gain_code = cfg[GAIN_HI:GAIN_LO];
    assign unipolar  = cfg[CODE_BIT];
    assign buf_en    = cfg[BUF_BIT];
    assign filt_rst  = cfg[SYNC_BIT];

    generate
        for (genvar i = 0; i < FACT_W; i++) begin : g_gain
            assign gain_factor[i] = (gain_code == GAIN_BITS'(i));
        end
    endgenerate

    // R2: the decoded gain is always a single power of two
    assert_gain_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(gain_factor) == 1));

endmodule

// File: tb/adc_setup_seq_test.sv
module adc_setup_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       upd_strobe = 1'b0;
    logic       data_rd = 1'b0;
    logic [2:0] gain_code;
    logic [7:0] gain_factor;
    logic       unipolar, buf_en, filt_rst, cal_zero, cal_full, drdy_n;

    always #2 clk = ~clk;

    adc_setup_seq uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .upd_strobe(upd_strobe), .data_rd(data_rd), .gain_code(gain_code),
        .gain_factor(gain_factor), .unipolar(unipolar), .buf_en(buf_en),
        .filt_rst(filt_rst), .cal_zero(cal_zero), .cal_full(cal_full), .drdy_n(drdy_n)
    );

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       drdy, cz, cf;
    } exp_t;

    exp_t       sb_q[$];
    event       sb_ev;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] reg_m = 8'h01;
    bit         done = 1'b0;

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                logic [7:0] act, exp;
                e = sb_q.pop_front();
                checks++;
                act = {rd_data};
                exp = e.rd;
                if (act !== exp || gain_code !== exp[5:3] || gain_factor !== (8'd1 << exp[5:3]) ||
                    unipolar !== exp[2] || buf_en !== exp[1] || filt_rst !== exp[0]) begin
                    errors++;
                    $display("FAIL %s: reg/fields act rd=%h gain=%0d fact=%0d u=%b b=%b f=%b exp rd=%h",
                             e.tag, act, gain_code, gain_factor, unipolar, buf_en, filt_rst, exp);
                end else if (drdy_n !== e.drdy || cal_zero !== e.cz || cal_full !== e.cf) begin
                    errors++;
                    $display("FAIL %s: act drdy_n=%b zero=%b full=%b exp drdy_n=%b zero=%b full=%b",
                             e.tag, drdy_n, cal_zero, cal_full, e.drdy, e.cz, e.cf);
                end
            end
        end
    end

    task automatic expect_now(string tag, logic d, logic z, logic f);
        exp_t e;
        e.tag = tag; e.rd = reg_m; e.drdy = d; e.cz = z; e.cf = f;
        sb_q.push_back(e);
        -> sb_ev;
        #0;
    endtask

    task automatic write_reg(logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        reg_m = v;
    endtask

    task automatic strobe(int n);
        for (int i = 0; i < n; i++) begin
            upd_strobe = 1'b1;
            @(negedge clk);
            upd_strobe = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic host_read();
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
    endtask

    // watchdog
    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: act running exp finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1 reset", 1, 0, 0);

        // R7: release sync in normal mode, settle over 3 strobes
        write_reg(8'h00);
        expect_now("R7 released", 1, 0, 0);
        strobe(2);
        expect_now("R7 two strobes", 1, 0, 0);
        strobe(1);
        expect_now("R7 third strobe", 0, 0, 0);

        // R8: read then strobe; simultaneous strobe and read
        host_read();
        expect_now("R8 read sets high", 1, 0, 0);
        strobe(1);
        expect_now("R8 strobe sets low", 0, 0, 0);
        host_read();
        upd_strobe = 1'b1; data_rd = 1'b1;
        @(negedge clk);
        upd_strobe = 1'b0; data_rd = 0;
        expect_now("R8 strobe beats read", 0, 0, 0);

        // R2: field decode
        write_reg(8'h2E);
        expect_now("R2 fields 0x2E", 0, 0, 0);
        write_reg(8'h38);
        expect_now("R2 fields 0x38", 0, 0, 0);

        // R3/R4/R5: self calibration, zero then full
        write_reg(8'h48);
        expect_now("R5 self cal start", 1, 1, 0);
        strobe(2);
        expect_now("R4 zero step not done", 1, 1, 0);
        strobe(1);
        expect_now("R3 self cal to full step", 1, 0, 1);
        strobe(2);
        expect_now("R4 full step not done", 1, 0, 1);
        strobe(1);
        reg_m = 8'h08;
        expect_now("R4 self cal end mode cleared", 0, 0, 0);

        // R3: zero-scale only
        write_reg(8'hA0);
        expect_now("R3 zero sys start", 1, 1, 0);
        strobe(3);
        reg_m = 8'h20;
        expect_now("R3 zero sys end", 0, 0, 0);

        // R3: full-scale only
        write_reg(8'hC6);
        expect_now("R3 full sys start", 1, 0, 1);
        strobe(3);
        reg_m = 8'h06;
        expect_now("R3 full sys end", 0, 0, 0);

        // R9: sync keeps low data-ready, reads still work
        write_reg(8'h01);
        expect_now("R9 sync keeps drdy low", 0, 0, 0);
        strobe(2);
        expect_now("R6 strobes ignored in hold", 0, 0, 0);
        host_read();
        expect_now("R9 read in hold", 1, 0, 0);

        // R6: calibration pending under sync
        write_reg(8'h41);
        strobe(4);
        expect_now("R6 cal pending", 1, 0, 0);

        // R10: abort mid-step restarts the count
        write_reg(8'h40);
        expect_now("R10 cal started", 1, 1, 0);
        strobe(2);
        write_reg(8'h80);
        expect_now("R10 restart zero", 1, 1, 0);
        strobe(2);
        expect_now("R10 count restarted", 1, 1, 0);
        strobe(1);
        reg_m = 8'h00;
        expect_now("R10 restarted cal end", 0, 0, 0);

        // R10: abort into hold keeps mode pending
        write_reg(8'hC0);
        strobe(1);
        write_reg(8'hC1);
        expect_now("R10 abort to hold", 1, 0, 0);
        strobe(3);
        expect_now("R10 hold keeps mode", 1, 0, 0);
        write_reg(8'h00);
        strobe(3);
        expect_now("R10 settle after abort", 0, 0, 0);

        // R10: normal-mode write during calibration goes to settling
        write_reg(8'hC0);
        strobe(1);
        write_reg(8'h10);
        expect_now("R10 normal abort", 1, 0, 0);
        strobe(3);
        expect_now("R10 settled after normal abort", 0, 0, 0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule